// File: doc/BRIEF.md
# FP8 to BF16 Widening Converter

This block widens packed 8-bit floating-point values into BF16. A 64-bit operand word carries eight byte lanes. A half-select input chooses either the lower four bytes or the upper four. Each chosen byte is read in one of two IEEE-style layouts: 1-4-3 with exponent bias 7, or 1-5-2 with exponent bias 15. Every value becomes one BF16 element, and the four BF16 elements are packed into a 64-bit result word.

Every FP8 value has an exact BF16 representation, so the block never rounds. Subnormal inputs are normalized with a leading-one search and are never flushed. Infinities and zeros keep their sign. A NaN always leaves the block as a quiet NaN with its payload kept. A signaling NaN anywhere in the selected lanes also raises an invalid flag.

The result is registered. A pulse on the input valid returns a result and a valid flag one clock later.

Top module: `fp8_bf16_widener`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `out_word` holds the conversion of the inputs sampled at that edge.
- R2: With `half_sel`=0, source bytes 0..3 (bits 31:0) are used; with `half_sel`=1, bytes 4..7 (bits 63:32). Selected byte i lands in `out_word[16i+15:16i]`.
- R3: With `fmt_sel`=0 a byte is sign[7], exponent[6:3], mantissa[2:0], bias 7. A normal value gives BF16 exponent e+120 and mantissa {m,4'b0000}.
- R4: With `fmt_sel`=1 a byte is sign[7], exponent[6:2], mantissa[1:0], bias 15. A normal value gives BF16 exponent e+112 and mantissa {m,5'b00000}.
- R5: A subnormal input (exponent 0, mantissa nonzero) converts to the exact normalized BF16 value of the same magnitude and sign.
- R6: An input with exponent 0 and mantissa 0 gives a BF16 zero with the same sign.
- R7: An all-ones exponent with a zero mantissa gives a BF16 infinity (exponent 0xFF, mantissa 0) with the same sign.
- R8: An all-ones exponent with a nonzero mantissa whose top bit is set is a quiet NaN. It gives exponent 0xFF and the FP8 mantissa left-aligned in the BF16 mantissa. The invalid flag is not raised.
- R9: A NaN whose mantissa top bit is clear is signaling. It gives the same output as R8 but with BF16 mantissa bit 6 forced to 1. `out_invalid` is raised together with `out_valid` when any selected lane is signaling.
- R10: After a clock edge with `in_valid` low, `out_valid` and `out_invalid` are low and `out_word` keeps its previous value.
- R11: While `rst_n` is low, `out_valid`, `out_invalid` and `out_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand word is valid this cycle |
| fmt_sel | input | 1 | Source layout: 0 = 1-4-3, 1 = 1-5-2 |
| half_sel | input | 1 | Lane group: 0 = bytes 0..3, 1 = bytes 4..7 |
| src_word | input | 64 | Eight packed FP8 values |
| out_valid | output | 1 | Result word is valid |
| out_word | output | 64 | Four packed BF16 results |
| out_invalid | output | 1 | A signaling NaN was converted |

## Verification
The block holds no state between words beyond the output register. A wrong decode therefore shows up as a wrong BF16 lane exactly one cycle after the offending input, with no lag and no carry-over into later words. A fault in the lane mux or the format select shows as a lane built from the wrong byte or the wrong exponent offset. Running every code of both layouts through both halves exposes such a fault within one word of the affected code. A fault in the flag or hold logic shows in the first idle cycle as `out_valid` or `out_invalid` left high, or as a result word that changes while idle.

// File: rtl/fp8_bf16_widener.sv
module fp8_bf16_widener #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              fmt_sel,
  input  logic              half_sel,
  input  logic [WORD_W-1:0] src_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_invalid
);
  localparam int HALF_W = WORD_W / 2;
  localparam int LANES  = WORD_W / 16;

  logic [HALF_W-1:0] src_half;
  logic [WORD_W-1:0] conv_word;
  logic [LANES-1:0]  lane_snan;

  assign src_half = half_sel ? src_word[WORD_W-1:HALF_W] : src_word[HALF_W-1:0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0]  b;
    logic        s;
    logic [4:0]  e;
    logic [2:0]  m;
    logic        e_max;
    logic [1:0]  lz;
    logic [2:0]  m_norm;
    logic [7:0]  off;
    logic [15:0] res;
    logic        sn;

    assign b      = src_half[8*i +: 8];
    assign s      = b[7];
    assign e      = fmt_sel ? b[6:2] : {1'b0, b[6:3]};
    assign m      = fmt_sel ? {b[1:0], 1'b0} : b[2:0];
    assign e_max  = fmt_sel ? (e == 5'd31) : (e == 5'd15);
    assign off    = fmt_sel ? 8'd112 : 8'd120;
    assign lz     = m[2] ? 2'd1 : (m[1] ? 2'd2 : 2'd3);
    assign m_norm = m << lz;

    always_comb begin
      sn = 1'b0;
      if (e_max) begin
        if (m == 3'd0) begin
          res = {s, 8'hFF, 7'd0};
        end else begin
          res = {s, 8'hFF, 1'b1, m[1:0], 4'd0};
          sn  = ~m[2];
        end
      end else if (e == 5'd0) begin
        if (m == 3'd0) res = {s, 15'd0};
        else           res = {s, off + 8'd1 - {6'd0, lz}, m_norm, 4'd0};
      end else begin
        res = {s, off + {3'd0, e}, m, 4'd0};
      end
    end

    assign conv_word[16*i +: 16] = res;
    assign lane_snan[i]          = sn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_invalid <= 1'b0;
      out_word    <= '0;
    end else begin
      out_valid   <= in_valid;
      out_invalid <= in_valid & (|lane_snan);
      if (in_valid) out_word <= conv_word;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_invalid && $stable(out_word)));  // R10
  AST_FLAG_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> out_valid);  // R9
  AST_INF_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !half_sel && !fmt_sel && src_word[6:0] == 7'h78)
      |=> (out_word[14:0] == 15'h7F80));  // R7
  AST_NAN_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word[14:7] == 8'hFF && out_word[6:0] != 7'd0) |-> out_word[6]);  // R9
endmodule

// File: tb/test_fp8_bf16_widener.sv
module test_fp8_bf16_widener;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        fmt_sel = 1'b0;
  logic        half_sel = 1'b0;
  logic [63:0] src_word = '0;
  logic        out_valid;
  logic [63:0] out_word;
  logic        out_invalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp8_bf16_widener i_fp8_bf16_widener (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_sel(fmt_sel),
    .half_sel(half_sel), .src_word(src_word), .out_valid(out_valid),
    .out_word(out_word), .out_invalid(out_invalid)
  );

  // {fmt, half, src, expected word, expected flag}
  localparam logic [130:0] VEC [5] = '{
    {1'b0, 1'b0, 64'hAAAA_AAAA_0038_0001, 64'h0000_3F80_0000_3B00, 1'b0},
    {1'b0, 1'b1, 64'h7FF8_7879_1234_5678, 64'h7FF0_FF80_7F80_7FD0, 1'b1},
    {1'b1, 1'b0, 64'h0000_0000_837D_013C, 64'hB840_7FE0_3780_3F80, 1'b1},
    {1'b1, 1'b1, 64'hFC7E_807B_0000_0000, 64'hFF80_7FC0_8000_4760, 1'b0},
    {1'b0, 1'b0, 64'h5555_5555_0882_7707, 64'h3C80_BB80_4370_3C60, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] ref_conv(input logic [7:0] b, input bit f);
    int mw, bias, e, m, emax, ex;
    real v;
    logic [63:0] d;
    logic s;
    s    = b[7];
    mw   = f ? 2 : 3;
    bias = f ? 15 : 7;
    emax = f ? 31 : 15;
    e    = f ? int'(b[6:2]) : int'(b[6:3]);
    m    = f ? int'(b[1:0]) : int'(b[2:0]);
    if (e == emax) begin
      if (m == 0) return {1'b0, s, 8'hFF, 7'd0};
      d = 64'(m) << (7 - mw);
      return {~d[6], s, 8'hFF, d[6:0] | 7'h40};
    end
    if (e == 0 && m == 0) return {1'b0, s, 15'd0};
    if (e == 0) v = real'(m) * (2.0 ** (1 - bias - mw));
    else        v = real'((1 << mw) + m) * (2.0 ** (e - bias - mw));
    d  = $realtobits(v);
    ex = int'(d[62:52]) - 896;
    return {1'b0, s, ex[7:0], d[51:45]};
  endfunction

  task automatic drive(input bit f, input bit h, input logic [63:0] w);
    fmt_sel  = f;
    half_sel = h;
    src_word = w;
    in_valid = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R11 reset word", out_word, 64'd0);
    chk("R11 reset flag", {63'd0, out_invalid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      drive(VEC[i][130], VEC[i][129], VEC[i][128:65]);
      chk("R1 valid", {63'd0, out_valid}, 64'd1);
      chk("table R2 R3 R4 R5 R6 R7 R8", out_word, VEC[i][64:1]);
      chk("R9 flag table", {63'd0, out_invalid}, {63'd0, VEC[i][0]});
    end

    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 256; c += 4) begin
        logic [31:0] sel;
        logic [63:0] w, exp_w;
        logic        exp_f;
        bit          h;
        h     = c[2];
        exp_f = 1'b0;
        for (int j = 0; j < 4; j++) begin
          logic [16:0] r;
          sel[8*j +: 8] = 8'(c + j);
          r = ref_conv(8'(c + j), f[0]);
          exp_w[16*j +: 16] = r[15:0];
          exp_f |= r[16];
        end
        w = h ? {sel, ~sel} : {~sel, sel};
        drive(f[0], h, w);
        chk(f ? "R4 R2 sweep" : "R3 R2 sweep", out_word, exp_w);
        chk("R9 sweep flag", {63'd0, out_invalid}, {63'd0, exp_f});
      end
    end

    drive(1'b0, 1'b0, 64'h0000_0000_0000_0079);
    in_valid = 1'b0;
    src_word = 64'h0101_0101_0101_0101;
    fmt_sel  = 1'b1;
    @(negedge clk);
    chk("R10 idle valid", {63'd0, out_valid}, 64'd0);
    chk("R10 idle flag", {63'd0, out_invalid}, 64'd0);
    chk("R10 idle word", out_word, 64'h0000_0000_0000_7FD0);
    @(negedge clk);
    chk("R10 idle word later", out_word, 64'h0000_0000_0000_7FD0);

    drive(1'b1, 1'b1, 64'h0080_0000_FFFF_FFFF);
    chk("R6 signed zero", out_word, 64'h0000_8000_0000_0000);
    drive(1'b0, 1'b1, 64'h8000_0000_0000_0000);
    chk("R6 signed zero 143", out_word, 64'h8000_0000_0000_0000);
    chk("R1 back to back", {63'd0, out_valid}, 64'd1);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule